// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the eight status bits of an I2C controller. The bus engine sends it one-cycle event pulses: start seen, stop seen, address matched, general call matched, second address matched, arbitration mismatch, and transmit-empty or receive-full raised. It also gets the current mode: master or slave, transmit or receive, I2C format or clocked-serial format, and two format-select bits. Each flag sets on its own event and clears under its own hardware rules.

Software reads the bits combinationally on `rdata`. It can clear bits 7 to 1 only by reading a bit as 1 and then writing 0 to that bit. The arming from that read is held separately for each bit. Bit 0 is a plain read/write acknowledge bit. In transmit mode, reads of bit 0 show the acknowledge returned by the receiver instead of the stored value.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset every flag is 0. The bit layout from bit 7 down to bit 0 is: error-stop, normal-stop, transfer-request, second-address, arbitration-lost, address-seen, general-call-seen, acknowledge.
- R2: A stop event in slave mode with I2C format sets error-stop (bit 7) if `frame_busy` is high, and sets normal-stop (bit 6) if it is low. A stop event in master mode sets neither.
- R3: A write clears a bit among 7..1 only when the written bit is 0 and that bit was read as 1 on an earlier cycle. Writing 0 with no earlier read, or writing 1, leaves the flag unchanged. Arming is held per bit.
- R4: A pulse on `irq_clr` clears bits 7, 6 and 5.
- R5: Arbitration-lost (bit 3) sets in master transmit mode on an SDA mismatch or an SCL-high-at-fall event. It does not set in any other mode.
- R6: A data-register write while transmitting, or a data-register read while receiving, clears bits 3, 2 and 1. A data-register access in the other direction leaves them unchanged.
- R7: Address-seen (bit 2) sets on an own-address or general-call match in slave receive with `fmt_sel`=0. General-call-seen (bit 1) sets on a general-call match in slave receive when `fmt_sel`=0 or `fmt_sel2`=0.
- R8: While `md_master` is 1, bits 4, 2 and 1 clear.
- R9: Second-address (bit 4) sets on a second-address match in slave receive with `fmt_sel2`=0. It clears on a start event.
- R10: Transfer-request (bit 5) sets on transmit-empty or receive-full. In I2C format it sets only while bit 4 is 1. In clocked-serial format (`md_i2c`=0) it sets unconditionally.
- R11: A hardware set wins over a software clear in the same cycle. That write still uses up the bit's arming, so a second write of 0 has no effect until the bit is read again.
- R12: A write stores `wdata[0]` as the acknowledge bit. Bit 0 reads back that stored value in receive mode and `ack_rx` in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition seen |
| ev_stop | input | 1 | Stop condition seen |
| frame_busy | input | 1 | A frame is still being sent |
| ev_own_addr | input | 1 | Own slave address matched |
| ev_gcall | input | 1 | General call address matched |
| ev_addr2 | input | 1 | Second slave address matched |
| ev_sda_mis | input | 1 | Internal SDA differs from pin at SCL rise |
| ev_scl_hi_fall | input | 1 | Internal SCL high at SCL fall |
| ev_tx_empty | input | 1 | Transmit-empty flag raised |
| ev_rx_full | input | 1 | Receive-full flag raised |
| md_master | input | 1 | 1 = master mode |
| md_xmit | input | 1 | 1 = transmit mode |
| md_i2c | input | 1 | 1 = I2C format, 0 = clocked-serial format |
| fmt_sel | input | 1 | Format select for the own address |
| fmt_sel2 | input | 1 | Format select for the second address |
| ack_rx | input | 1 | Acknowledge sampled from the receiver |
| rd_en | input | 1 | CPU read of the status register |
| wr_en | input | 1 | CPU write of the status register |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Status read value |
| dr_wr | input | 1 | CPU write of the data register |
| dr_rd | input | 1 | CPU read of the data register |
| irq_clr | input | 1 | Interrupt-request flag cleared |

## Verification
The properties assume the bus engine sends each event as a single-cycle pulse. They also assume that a clear event and a set event for the same bit come together only where a requirement defines the outcome, so each clear check excludes the cycles in which that bit's set term is active. The stimulus changes inputs only at the falling edge. It holds the mode steady for a whole cycle around each event, and it never issues a status read and a status write in the same cycle.

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       frame_busy,
  input  logic       ev_own_addr,
  input  logic       ev_gcall,
  input  logic       ev_addr2,
  input  logic       ev_sda_mis,
  input  logic       ev_scl_hi_fall,
  input  logic       ev_tx_empty,
  input  logic       ev_rx_full,
  input  logic       md_master,
  input  logic       md_xmit,
  input  logic       md_i2c,
  input  logic       fmt_sel,
  input  logic       fmt_sel2,
  input  logic       ack_rx,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       dr_wr,
  input  logic       dr_rd,
  input  logic       irq_clr
);
  localparam int unsigned NF = 7;

  logic [NF:1] flg, arm, set_v, hw_clr, sw_clr, flg_nxt, arm_nxt;
  logic        ack_q;
  logic        slv_rx, dr_touch, slv_i2c;

  assign slv_rx   = ~md_master & ~md_xmit;
  assign slv_i2c  = ~md_master & md_i2c;
  assign dr_touch = (dr_wr & md_xmit) | (dr_rd & ~md_xmit);

  assign set_v[7] = ev_stop & slv_i2c & frame_busy;
  assign set_v[6] = ev_stop & slv_i2c & ~frame_busy;
  assign set_v[5] = (ev_tx_empty | ev_rx_full) & (~md_i2c | flg[4]);
  assign set_v[4] = ev_addr2 & slv_rx & ~fmt_sel2;
  assign set_v[3] = md_master & md_xmit & (ev_sda_mis | ev_scl_hi_fall);
  assign set_v[2] = (ev_own_addr | ev_gcall) & slv_rx & ~fmt_sel;
  assign set_v[1] = ev_gcall & slv_rx & (~fmt_sel | ~fmt_sel2);

  assign hw_clr[7] = irq_clr;
  assign hw_clr[6] = irq_clr;
  assign hw_clr[5] = irq_clr;
  assign hw_clr[4] = ev_start | md_master;
  assign hw_clr[3] = dr_touch;
  assign hw_clr[2] = dr_touch | md_master;
  assign hw_clr[1] = dr_touch | md_master;

  assign sw_clr  = {NF{wr_en}} & ~wdata[NF:1] & arm;
  assign flg_nxt = set_v | (flg & ~(hw_clr | sw_clr));
  assign arm_nxt = flg_nxt & ~sw_clr & (arm | ({NF{rd_en}} & flg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg   <= '0;
      arm   <= '0;
      ack_q <= 1'b0;
    end else begin
      flg <= flg_nxt;
      arm <= arm_nxt;
      if (wr_en) ack_q <= wdata[0];
    end
  end

  assign rdata = {flg, md_xmit ? ack_rx : ack_q};
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       frame_busy,
  input logic       ev_own_addr,
  input logic       ev_gcall,
  input logic       ev_addr2,
  input logic       ev_sda_mis,
  input logic       ev_scl_hi_fall,
  input logic       ev_tx_empty,
  input logic       ev_rx_full,
  input logic       md_master,
  input logic       md_xmit,
  input logic       md_i2c,
  input logic       fmt_sel,
  input logic       fmt_sel2,
  input logic       ack_rx,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       dr_wr,
  input logic       dr_rd,
  input logic       irq_clr
);
  p_estp_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !md_master && md_i2c && frame_busy |=> rdata[7]);
  p_stop_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !md_master && md_i2c && !frame_busy |=> rdata[6]);
  p_irq_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !ev_stop && !ev_tx_empty && !ev_rx_full |=> rdata[7:5] == 3'b000);
  p_al_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    md_master && md_xmit && (ev_sda_mis || ev_scl_hi_fall) |=> rdata[3]);
  p_dr_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dr_wr && md_xmit) || (dr_rd && !md_xmit)) &&
    !(md_master && md_xmit && (ev_sda_mis || ev_scl_hi_fall)) |=> !rdata[3]);
  p_master_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    md_master |=> rdata[4] == 1'b0 && rdata[2] == 1'b0 && rdata[1] == 1'b0);
  p_start_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !(ev_addr2 && !md_master && !md_xmit && !fmt_sel2) |=> !rdata[4]);
  p_ack_view_r12: assert property (@(posedge clk) disable iff (!rst_n)
    md_xmit |-> rdata[0] == ack_rx);
  p_ack_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (md_xmit || rdata[0] == $past(wdata[0])));
endmodule

bind i2c_stat_flags i2c_stat_flags_chk u_chk (.*);

// File: tb/sim_i2c_stat_flags.sv
module sim_i2c_stat_flags;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic [4:0] md = '0;
  logic ack_rx = 1'b0, rd_en = 1'b0, wr_en = 1'b0, dr_wr = 1'b0, dr_rd = 1'b0, irq_clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_stat_flags u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev[9]), .ev_stop(ev[8]), .frame_busy(ev[7]), .ev_own_addr(ev[6]),
    .ev_gcall(ev[5]), .ev_addr2(ev[4]), .ev_sda_mis(ev[3]), .ev_scl_hi_fall(ev[2]),
    .ev_tx_empty(ev[1]), .ev_rx_full(ev[0]),
    .md_master(md[4]), .md_xmit(md[3]), .md_i2c(md[2]), .fmt_sel(md[1]), .fmt_sel2(md[0]),
    .ack_rx(ack_rx), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .dr_wr(dr_wr), .dr_rd(dr_rd), .irq_clr(irq_clr)
  );

  localparam logic [9:0] E_NONE = 10'b0000000000, E_START = 10'b1000000000,
    E_STOP = 10'b0100000000, E_BUSY = 10'b0010000000, E_ADDR = 10'b0001000000,
    E_GC = 10'b0000100000, E_A2 = 10'b0000010000, E_MIS = 10'b0000001000,
    E_SCLH = 10'b0000000100, E_TDRE = 10'b0000000010, E_RDRF = 10'b0000000001;
  localparam logic [4:0] M_SR = 5'b00100, M_ST = 5'b01100, M_MT = 5'b11100,
    M_MR = 5'b10100, M_SR_FS = 5'b00110, M_SR_FSX = 5'b00101, M_SR_BOTH = 5'b00111,
    M_CLK = 5'b00000;
  localparam int NV = 16;
  localparam logic [21:0] TBL [NV] = '{
    {E_ADDR,          M_SR,      7'b0000010},  // R7
    {E_GC,            M_SR,      7'b0000011},  // R7
    {E_NONE,          M_MR,      7'b0000000},  // R8
    {E_GC,            M_SR_FS,   7'b0000001},  // R7
    {E_NONE,          M_MT,      7'b0000000},  // R8
    {E_ADDR,          M_SR_BOTH, 7'b0000000},  // R7
    {E_TDRE,          M_SR,      7'b0000000},  // R10
    {E_A2,            M_SR,      7'b0001000},  // R9
    {E_RDRF,          M_SR,      7'b0011000},  // R10
    {E_START,         M_SR,      7'b0010000},  // R9
    {E_STOP | E_BUSY, M_ST,      7'b1010000},  // R2
    {E_STOP,          M_ST,      7'b1110000},  // R2
    {E_MIS,           M_MT,      7'b1110100},  // R5
    {E_SCLH,          M_MR,      7'b1110100},  // R5
    {E_STOP,          M_MT,      7'b1110100},  // R2
    {E_A2,            M_SR_FSX,  7'b1110100}   // R9
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(logic [9:0] e, logic [4:0] m);
    ev = e; md = m;
    tick();
    ev = '0;
  endtask

  task automatic do_rd();
    rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic do_wr(logic [7:0] d);
    wr_en = 1'b1; wdata = d; tick(); wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset value", rdata, 8'h00);
    tick();
    chk("R1 idle after reset", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      pulse(TBL[i][21:12], TBL[i][11:7]);
      chk($sformatf("table step %0d (R2 R5 R7 R8 R9 R10)", i), {1'b0, rdata[7:1]}, {1'b0, TBL[i][6:0]});
    end

    md = M_SR; irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R4 irq clear drops bits 7..5", {1'b0, rdata[7:1]}, 8'b00000100);

    md = M_MT; dr_rd = 1'b1; tick(); dr_rd = 1'b0;
    chk("R6 read while transmitting keeps AL", {1'b0, rdata[7:1]}, 8'b00000100);
    dr_wr = 1'b1; tick(); dr_wr = 1'b0;
    chk("R6 write while transmitting clears AL", {1'b0, rdata[7:1]}, 8'b00000000);

    pulse(E_ADDR, M_SR);
    dr_wr = 1'b1; tick(); dr_wr = 1'b0;
    chk("R6 write while receiving keeps address flag", {1'b0, rdata[7:1]}, 8'b00000010);
    dr_rd = 1'b1; tick(); dr_rd = 1'b0;
    chk("R6 read while receiving clears address flag", {1'b0, rdata[7:1]}, 8'b00000000);

    pulse(E_TDRE, M_CLK);
    chk("R10 clocked format sets transfer-request", {1'b0, rdata[7:1]}, 8'b00010000);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R4 irq clear drops transfer-request", {1'b0, rdata[7:1]}, 8'b00000000);

    pulse(E_MIS, M_MT);
    do_wr(8'h00);
    chk("R3 write 0 without read has no effect", {1'b0, rdata[7:1]}, 8'b00000100);
    do_rd();
    do_wr(8'hFE);
    chk("R3 write 1 after read has no effect", {1'b0, rdata[7:1]}, 8'b00000100);
    do_wr(8'h00);
    chk("R3 write 0 after read clears", {1'b0, rdata[7:1]}, 8'b00000000);

    pulse(E_MIS, M_MT);
    do_rd();
    pulse(E_ADDR, M_SR);
    chk("R7 address flag beside AL", {1'b0, rdata[7:1]}, 8'b00000110);
    do_wr(8'h00);
    chk("R3 arming is per bit", {1'b0, rdata[7:1]}, 8'b00000010);
    do_rd();
    do_wr(8'h00);
    chk("R3 clear after second read", {1'b0, rdata[7:1]}, 8'b00000000);

    pulse(E_MIS, M_MT);
    do_rd();
    wr_en = 1'b1; wdata = 8'h00; ev = E_MIS; tick(); wr_en = 1'b0; ev = '0;
    chk("R11 set wins over clear", {1'b0, rdata[7:1]}, 8'b00000100);
    do_wr(8'h00);
    chk("R11 arming used up by lost clear", {1'b0, rdata[7:1]}, 8'b00000100);
    do_rd();
    do_wr(8'h00);
    chk("R3 clear after rearming", {1'b0, rdata[7:1]}, 8'b00000000);

    md = M_SR; do_wr(8'h01);
    chk("R12 stored ack reads back in receive", rdata, 8'h01);
    md = M_ST; ack_rx = 1'b0; tick();
    chk("R12 transmit shows receiver ack 0", rdata, 8'h00);
    ack_rx = 1'b1; tick();
    chk("R12 transmit shows receiver ack 1", rdata, 8'h01);
    md = M_SR; do_wr(8'h00);
    chk("R12 stored ack cleared by write", rdata, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule